// File: doc/BRIEF.md
# Clocked SRAM Bus Controller

This block sits between a simple processor-side request port and a word-wide storage array held inside the block. The port has active-low strobes for chip select, read and write, an address bus, and one bidirectional data bus. The controller samples the strobes and the address on the rising clock edge. It performs the access one cycle after that edge. A compile-time count of wait states can stretch the access so that a fast requester can still meet a slow memory's access time. A `ready` output goes low while an access is in progress.

When a read completes, the controller drives the stored word onto the shared data bus. It drives it only while chip select and the read strobe are both held low. The output enable is a combinational function of those strobes, so the bus is released in the same instant that the read strobe rises, without waiting for a clock edge. A write takes the data that is on the bus at the capture edge. A request with both strobes low is refused and flagged. An access has to be followed by both strobes going back high before the next request is accepted.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `err` is 0 and `data_oe` is 0.
- R2: While `cs_n` is 1, no access starts: `ready` stays 1 whatever `rd_n` and `wr_n` do.
- R3: A read from an address returns, on `data`, the word most recently written to that address. Writes to other addresses do not change it.
- R4: At a rising edge in the idle state where `cs_n`=0 and exactly one strobe is 0, the request is captured. `ready` is 0 from that edge until the edge WAIT_CYCLES+1 cycles later, when it returns to 1.
- R5: Strobe and address changes made while `ready` is 0 have no effect on the access in progress and do not start another access.
- R6: A write stores the value present on `data` at the capture edge. Later changes of `data` are ignored.
- R7: At an idle-state edge where `cs_n`, `rd_n` and `wr_n` are all 0, `err` is 1 for exactly the next cycle. No access is made (the array is unchanged) and `ready` stays 1.
- R8: `data_oe` is 1 only after a read has completed, and only while `cs_n`=0 and `rd_n`=0. It falls in the same instant that `rd_n` rises, with no clock edge in between.
- R9: After an access or a refused request, no new request is accepted until an edge at which `cs_n`=1 or both strobes are 1. A strobe that stays low does not repeat the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 8 | Word address, sampled at the capture edge |
| data | inout | 16 | Shared data bus: write data in, read data out |
| data_oe | output | 1 | High while the block drives `data` |
| ready | output | 1 | Low while an access is in progress |
| err | output | 1 | One-cycle flag for a request with both strobes low |

## Verification
A request captured at edge k drops `ready` in the cycle after k. The write commit or the read data arrives at edge k+WAIT_CYCLES+1, and that is where `ready` rises and `data_oe` may first go high. `err` is due only in the single cycle that follows a refused edge. The bench keeps a behavioural model that is advanced on each rising edge from the inputs held over that edge. It compares all outputs at the falling edge. The bus release is checked one time unit after `rd_n` rises, with no clock edge in between.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } ctl_op_e;

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(WAIT_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= WAIT_CYCLES);

endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = mem_q[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = rdata_q;

    // R3
    one_port_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_bus_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int WAIT_CYCLES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    inout  wire  [DW-1:0] data,
    output logic          data_oe,
    output logic          ready,
    output logic          err
);
    localparam int RUNW = $clog2(WAIT_CYCLES + 3);

    typedef struct packed {
        ctl_state_e    state;
        ctl_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          err;
    } ctl_regs_t;

    ctl_regs_t     r_d, r_q;
    logic          cnt_load, cnt_done;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] bus_in;

    assign bus_in = data;

    always_comb begin
        r_d      = r_q;
        r_d.err  = 1'b0;
        cnt_load = 1'b0;
        mem_we   = 1'b0;
        mem_re   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (!cs_n) begin
                    if (!rd_n && !wr_n) begin
                        r_d.err   = 1'b1;
                        r_d.op    = OP_NONE;
                        r_d.state = ST_HOLD;
                    end else if (!rd_n || !wr_n) begin
                        r_d.op    = !rd_n ? OP_READ : OP_WRITE;
                        r_d.addr  = addr;
                        r_d.wdata = bus_in;
                        r_d.state = ST_BUSY;
                        cnt_load  = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (cnt_done) begin
                    mem_we    = (r_q.op == OP_WRITE);
                    mem_re    = (r_q.op == OP_READ);
                    r_d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (cs_n || (rd_n && wr_n)) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.op    <= OP_NONE;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    sram_wait_cnt #(
        .WAIT_CYCLES(WAIT_CYCLES)
    ) i_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cnt_load),
        .done (cnt_done)
    );

    sram_store #(
        .AW(AW),
        .DW(DW)
    ) i_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .re   (mem_re),
        .addr (r_q.addr),
        .wdata(r_q.wdata),
        .rdata(mem_rdata)
    );

    assign ready   = (r_q.state != ST_BUSY);
    assign err     = r_q.err;
    assign data_oe = (r_q.state == ST_HOLD) && (r_q.op == OP_READ) && !cs_n && !rd_n;
    assign data    = data_oe ? mem_rdata : {DW{1'bz}};

    // Length of the current low stretch of ready, for the R4 check.
    logic [RUNW-1:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      low_run_q <= '0;
        else if (!ready) low_run_q <= low_run_q + 1'b1;
        else             low_run_q <= '0;
    end

    // R4
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(low_run_q) <= WAIT_CYCLES + 1);

    // R4
    ready_rise_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && int'(low_run_q) == WAIT_CYCLES) |=> ready);

    // R7
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R7
    err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ready);

    // R8
    oe_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ready);

    // R2
    deselect_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cs_n) |=> ready);

endmodule

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  addr = '0;
    logic        tb_drv = 1'b0;
    logic [15:0] tb_data = '0;
    wire  [15:0] bus;
    logic        data_oe, ready, err;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    assign bus = tb_drv ? tb_data : 16'hzzzz;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bus_ctrl #(.AW(8), .DW(16), .WAIT_CYCLES(W)) i_sram_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .data(bus), .data_oe(data_oe), .ready(ready), .err(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 idle, 1 waiting, 2 finished
    int m_phase = 0, m_left = 0, m_kind = 0, m_addr = 0, m_wd = 0, m_rd = 0;
    bit m_err = 0;
    int m_mem [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_kind = 0; m_err = 0; m_left = 0;
        end else begin
            m_err = 0;
            if (m_phase == 0) begin
                if (!cs_n && !rd_n && !wr_n) begin
                    m_err = 1; m_kind = 0; m_phase = 2;
                end else if (!cs_n && (!rd_n || !wr_n)) begin
                    m_kind = !rd_n ? 1 : 2; m_addr = addr; m_wd = bus;
                    m_left = W; m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (m_left == 0) begin
                    if (m_kind == 2) m_mem[m_addr] = m_wd;
                    else m_rd = m_mem.exists(m_addr) ? m_mem[m_addr] : 0;
                    m_phase = 2;
                end else m_left--;
            end else if (cs_n || (rd_n && wr_n)) m_phase = 0;
        end
    end

    function automatic int exp_oe();
        return (m_phase == 2 && m_kind == 1 && !cs_n && !rd_n) ? 1 : 0;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 ready", ready, (m_phase != 1) ? 1 : 0);
            chk("R7 err", err, m_err);
            chk("R8 data_oe", data_oe, exp_oe());
            if (exp_oe() == 1) chk("R3 read data", bus, m_rd);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic release_all();
        cs_n = 1; rd_n = 1; wr_n = 1; tb_drv = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        cs_n = 0; wr_n = 0; rd_n = 1; addr = a; tb_drv = 1; tb_data = d;
        step(1);
        // R6 bus changes after capture are ignored; R5 address change too
        tb_data = ~d; addr = a ^ 8'h11;
        step(W + 1);
        release_all();
        step(1);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [15:0] exp, input string tag);
        cs_n = 0; rd_n = 0; wr_n = 1; addr = a; tb_drv = 0;
        step(1);
        addr = a ^ 8'h22;
        step(W + 1);
        chk({tag, " value"}, bus, exp);
        step(2);
        // R9 held strobe: still ready, no repeat access
        chk("R9 held strobe no new access", ready, 1);
        rd_n = 1;
        #1;
        chk("R8 combinational release", data_oe, 0);
        cs_n = 1;
        step(1);
    endtask

    initial begin
        step(3);
        chk("R1 ready after reset", ready, 1);
        chk("R1 err after reset", err, 0);
        chk("R1 oe after reset", data_oe, 0);
        rst_n = 1;
        step(2);

        // R2 strobes without chip select
        cs_n = 1; rd_n = 0; addr = 8'h05; step(3);
        chk("R2 deselected ready", ready, 1);
        wr_n = 0; rd_n = 1; step(2);
        chk("R2 deselected write ignored", ready, 1);
        release_all(); step(1);

        do_write(8'h00, 16'h1234);
        do_write(8'hFF, 16'hBEEF);
        do_write(8'h5A, 16'hA5C3);
        do_read(8'h00, 16'h1234, "R3 addr00");
        do_read(8'hFF, 16'hBEEF, "R3 addrFF");
        do_read(8'h5A, 16'hA5C3, "R6 captured data");

        // R5 read strobe pulsed while a write is in progress
        cs_n = 0; wr_n = 0; addr = 8'h33; tb_drv = 1; tb_data = 16'h0F0F;
        step(1);
        wr_n = 1; rd_n = 0; tb_drv = 0;
        step(1);
        chk("R5 busy ignores read", ready, 0);
        rd_n = 1;
        step(W + 1);
        release_all(); step(1);
        do_read(8'h33, 16'h0F0F, "R5 write intact");

        // R7 both strobes low
        cs_n = 0; rd_n = 0; wr_n = 0; addr = 8'h5A; tb_drv = 1; tb_data = 16'h7777;
        step(1);
        chk("R7 err raised", err, 1);
        chk("R7 ready stays high", ready, 1);
        step(1);
        chk("R7 err one cycle", err, 0);
        release_all(); step(1);
        do_read(8'h5A, 16'hA5C3, "R7 array unchanged");

        // R3 overwrite and neighbour
        do_write(8'h5A, 16'h0001);
        do_write(8'h5B, 16'hFFFE);
        do_read(8'h5A, 16'h0001, "R3 overwrite");
        do_read(8'h00, 16'h1234, "R3 neighbour intact");

        step(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule